// File: doc/BRIEF.md
# Shared Response Buffer Write Arbiter

This block decides, cycle by cycle, who may write into a transmit response packet buffer that serves two producers. One is a user-side packet writer; the other is an internal responder that emits register-access replies and end-of-chain replies. The user sees a buffer-available flag. When the internal responder asks for the buffer, the flag is dropped. A user packet that starts within a short grace window after the drop is still taken whole. A user packet that starts later is refused, and a reject strobe tells the user so. The responder is granted the buffer only once any accepted user packet has been fully stored. Packets of the two producers therefore never interleave.

Each beat carries a 64-bit word as two 32-bit halves, start and end markers, and a 3-bit empty count. For a response that is only a command, the upper half is don't-care. Beats land in a small pointer-based FIFO model of the buffer, which is read from the far side. The flag also drops whenever free space is smaller than one maximum-length packet. Other buffer classes, which only lose availability through user writes, are not part of this block.

Top module: `rspBufArbiter`

## Requirements
- R1: After reset `usrAvail` is 1, `usrReject` is 0, `intGrant` is 0 and `rdValid` is 0.
- R2: When `intReq` is 1 in a cycle where `usrAvail` is 1, `usrAvail` is 0 in the next cycle.
- R3: A user packet whose first beat arrives in one of the first `GRACE` cycles with `usrAvail` low after an internal request is stored completely, including any beats that arrive after the window.
- R4: A user packet whose first beat arrives while `usrAvail` is low and outside the grace window is not stored. `usrReject` is 1 in the cycle after each of its beats, through the beat with `usrEop`.
- R5: `intGrant` rises only after the end beat of an accepted user packet has been stored. A user beat and an internal beat are never stored in the same cycle.
- R6: `usrAvail` returns to 1 in the cycle after the internal beat with `intEop` is written, provided at least `MAX_BEATS` entries are free.
- R7: `usrAvail` is 0 whenever fewer than `MAX_BEATS` entries are free, and a user packet started then is rejected as in R4.
- R8: Stored beats are read back in write order. Each beat returns all of its fields: `rdDatLo`, `rdDatHi`, `rdSop`, `rdEop` and `rdEmpty` (3-bit empty count).
- R9: Internal beats presented while `intGrant` is 0 are ignored and never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usrAvail | output | 1 | Buffer available to the user writer |
| usrWrEn | input | 1 | User beat valid |
| usrDatLo | input | 32 | User data, lower half |
| usrDatHi | input | 32 | User data, upper half |
| usrSop | input | 1 | User start-of-packet |
| usrEop | input | 1 | User end-of-packet |
| usrEmpty | input | 3 | User empty-count field |
| usrReject | output | 1 | A user beat was refused in the previous cycle |
| intReq | input | 1 | Internal responder has a packet to write |
| intGrant | output | 1 | Internal responder owns the buffer |
| intWrEn | input | 1 | Internal beat valid |
| intDatLo | input | 32 | Internal data, lower half |
| intDatHi | input | 32 | Internal data, upper half |
| intSop | input | 1 | Internal start-of-packet |
| intEop | input | 1 | Internal end-of-packet |
| intEmpty | input | 3 | Internal empty-count field |
| rdEn | input | 1 | Pop one beat from the buffer |
| rdValid | output | 1 | Buffer holds at least one beat |
| rdDatLo | output | 32 | Head beat, lower half |
| rdDatHi | output | 32 | Head beat, upper half |
| rdSop | output | 1 | Head beat start marker |
| rdEop | output | 1 | Head beat end marker |
| rdEmpty | output | 3 | Head beat empty count |

## Verification
Two events can fall in the same cycle: an internal request arriving, and a user packet starting while the flag is still high. The same holds for the last grace cycle and the first cycle in which starts are refused. The vector table provokes both. One row raises `intReq` together with a user start beat. Other rows place a start in the single grace cycle, or one cycle past it. The flag, reject and grant are checked every cycle. The buffer is then drained, and each beat is compared with the sequence the requirements predict, which shows that accepted packets were stored whole and that refused or ungranted beats left no trace.

// File: rtl/rspArbPkg.sv
package rspArbPkg;
  localparam int HALF_W  = 32;
  localparam int EMPTY_W = 3;

  typedef struct packed {
    logic userWr;
    logic intWr;
  } wrStrobe_t;

  typedef struct packed {
    logic [HALF_W-1:0]  lo;
    logic [HALF_W-1:0]  hi;
    logic               sop;
    logic               eop;
    logic [EMPTY_W-1:0] empty;
  } beat_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRACE = 2'd1,
    ST_HOLD  = 2'd2,
    ST_INT   = 2'd3
  } arbState_t;
endpackage

// File: rtl/rspArbCtrl.sv
module rspArbCtrl
  import rspArbPkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int MAX_BEATS = 4,
  parameter int GRACE     = 1,
  localparam int FREE_W   = $clog2(DEPTH) + 1,
  localparam int CNT_W    = $clog2(GRACE + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intReq,
  input  logic              usrWrEn,
  input  logic              usrEop,
  input  logic              intWrEn,
  input  logic              intEop,
  input  logic [FREE_W-1:0] freeSlots,
  output logic              usrAvail,
  output logic              usrReject,
  output logic              intGrant,
  output wrStrobe_t         strb
);
  arbState_t        state, stateNxt;
  logic [CNT_W-1:0] graceCnt, graceCntNxt;
  logic             userInPkt, rejectPkt;
  logic             roomOk, startOk, userAcc, userRej;

  always_comb begin
    roomOk      = freeSlots >= FREE_W'(MAX_BEATS);
    usrAvail    = (state == ST_IDLE) && roomOk;
    intGrant    = (state == ST_INT);
    startOk     = usrAvail || (state == ST_GRACE);
    userAcc     = usrWrEn && (userInPkt || (!rejectPkt && startOk));
    userRej     = usrWrEn && !userAcc;
    strb.userWr = userAcc;
    strb.intWr  = intGrant && intWrEn;
  end

  always_comb begin
    stateNxt    = state;
    graceCntNxt = graceCnt;
    unique case (state)
      ST_IDLE: if (intReq) begin
        stateNxt    = roomOk ? ST_GRACE : ST_HOLD;
        graceCntNxt = '0;
      end
      ST_GRACE: begin
        if (graceCnt == CNT_W'(GRACE - 1)) stateNxt = ST_HOLD;
        else graceCntNxt = graceCnt + 1'b1;
      end
      ST_HOLD: if (!userInPkt && roomOk) stateNxt = ST_INT;
      ST_INT:  if (strb.intWr && intEop) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      graceCnt  <= '0;
      userInPkt <= 1'b0;
      rejectPkt <= 1'b0;
      usrReject <= 1'b0;
    end else begin
      state     <= stateNxt;
      graceCnt  <= graceCntNxt;
      usrReject <= userRej;
      if (userAcc) userInPkt <= !usrEop;
      if (userRej) rejectPkt <= !usrEop;
    end
  end

  AST_AVAIL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    intReq && usrAvail |=> !usrAvail); // R2
  AST_LATE_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD || state == ST_INT) && usrWrEn && !userInPkt |=> usrReject); // R4
  AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (!rstN)
    intGrant |-> !userInPkt); // R5
  AST_REOPEN: assert property (@(posedge clk) disable iff (!rstN)
    strb.intWr && intEop |=> !intGrant); // R6
endmodule

// File: rtl/rspArbDatapath.sv
module rspArbDatapath
  import rspArbPkg::*;
#(
  parameter int DEPTH   = 16,
  localparam int AW     = $clog2(DEPTH),
  localparam int FREE_W = AW + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           strb,
  input  beat_t               usrBeat,
  input  beat_t               intBeat,
  input  logic                rdEn,
  output beat_t               rdBeat,
  output logic                rdValid,
  output logic [FREE_W-1:0]   freeSlots
);
  beat_t            mem [DEPTH];
  logic [AW:0]      wrPtr, rdPtr, used;
  logic             wr, rd, full;
  beat_t            wrBeat;

  always_comb begin
    used      = wrPtr - rdPtr;
    freeSlots = FREE_W'(DEPTH) - used;
    full      = (used == (AW+1)'(DEPTH));
    rdValid   = (used != '0);
    wr        = strb.userWr || strb.intWr;
    rd        = rdEn && rdValid;
    wrBeat    = strb.intWr ? intBeat : usrBeat;
    rdBeat    = mem[rdPtr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wrPtr[AW-1:0]] <= wrBeat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (wr) wrPtr <= wrPtr + 1'b1;
      if (rd) rdPtr <= rdPtr + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    wr |-> !full); // R7
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.userWr, strb.intWr}) <= 1); // R5
endmodule

// File: rtl/rspBufArbiter.sv
module rspBufArbiter
  import rspArbPkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int MAX_BEATS = 4,
  parameter int GRACE     = 1,
  localparam int FREE_W   = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  output logic               usrAvail,
  input  logic               usrWrEn,
  input  logic [HALF_W-1:0]  usrDatLo,
  input  logic [HALF_W-1:0]  usrDatHi,
  input  logic               usrSop,
  input  logic               usrEop,
  input  logic [EMPTY_W-1:0] usrEmpty,
  output logic               usrReject,
  input  logic               intReq,
  output logic               intGrant,
  input  logic               intWrEn,
  input  logic [HALF_W-1:0]  intDatLo,
  input  logic [HALF_W-1:0]  intDatHi,
  input  logic               intSop,
  input  logic               intEop,
  input  logic [EMPTY_W-1:0] intEmpty,
  input  logic               rdEn,
  output logic               rdValid,
  output logic [HALF_W-1:0]  rdDatLo,
  output logic [HALF_W-1:0]  rdDatHi,
  output logic               rdSop,
  output logic               rdEop,
  output logic [EMPTY_W-1:0] rdEmpty
);
  wrStrobe_t         strb;
  logic [FREE_W-1:0] freeSlots;
  beat_t             usrBeat, intBeat, rdBeat;

  assign usrBeat = '{lo: usrDatLo, hi: usrDatHi, sop: usrSop, eop: usrEop, empty: usrEmpty};
  assign intBeat = '{lo: intDatLo, hi: intDatHi, sop: intSop, eop: intEop, empty: intEmpty};
  assign rdDatLo = rdBeat.lo;
  assign rdDatHi = rdBeat.hi;
  assign rdSop   = rdBeat.sop;
  assign rdEop   = rdBeat.eop;
  assign rdEmpty = rdBeat.empty;

  rspArbCtrl #(.DEPTH(DEPTH), .MAX_BEATS(MAX_BEATS), .GRACE(GRACE)) u_ctrl (
    .clk(clk), .rstN(rstN), .intReq(intReq), .usrWrEn(usrWrEn), .usrEop(usrEop),
    .intWrEn(intWrEn), .intEop(intEop), .freeSlots(freeSlots),
    .usrAvail(usrAvail), .usrReject(usrReject), .intGrant(intGrant), .strb(strb)
  );

  rspArbDatapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .usrBeat(usrBeat), .intBeat(intBeat),
    .rdEn(rdEn), .rdBeat(rdBeat), .rdValid(rdValid), .freeSlots(freeSlots)
  );
endmodule

// File: tb/rspBufArbiter_bench.sv
module rspBufArbiter_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic usrAvail, usrWrEn, usrSop, usrEop, usrReject;
  logic [31:0] usrDatLo, usrDatHi, intDatLo, intDatHi, rdDatLo, rdDatHi;
  logic [2:0] usrEmpty, intEmpty, rdEmpty;
  logic intReq, intGrant, intWrEn, intSop, intEop, rdEn, rdValid, rdSop, rdEop;

  always #10 clk = ~clk;

  rspBufArbiter u_rspBufArbiter (.*);

  // {intReq, usrWrEn, usrSop, usrEop, intWrEn, intEop, expAvail, expReject, expGrant, expStore[1:0]}
  // expStore: 0 nothing stored, 1 user beat stored, 2 internal beat stored
  localparam int NV = 21;
  localparam logic [10:0] VEC [NV] = '{
    11'b000000_100_00, 11'b011100_100_01, 11'b100000_100_00, 11'b011000_000_01,
    11'b010000_000_01, 11'b010100_000_01, 11'b011100_000_00, 11'b000010_011_10,
    11'b000011_001_10, 11'b000000_100_00, 11'b100000_100_00, 11'b000000_000_00,
    11'b011000_000_00, 11'b010111_011_10, 11'b000000_110_00, 11'b000011_100_00,
    11'b111000_100_01, 11'b010100_000_01, 11'b000000_000_00, 11'b000011_001_10,
    11'b000000_100_00};

  int checks = 0, fails = 0, cycles = 0;
  logic [69:0] expQ [32];
  int wrIdx = 0, rdIdx = 0;
  logic intSopNext = 1'b1;

  task automatic chk(input string req, input logic [69:0] act, input logic [69:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleIn();
    usrWrEn = 0; usrSop = 0; usrEop = 0; intReq = 0; intWrEn = 0; intSop = 0; intEop = 0; rdEn = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idleIn();
    usrDatLo = 0; usrDatHi = 0; usrEmpty = 0; intDatLo = 0; intDatHi = 0; intEmpty = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", {usrAvail, usrReject, intGrant, rdValid}, 70'b1000);

    // Table walk: R2 R3 R4 R5 R6 R9 timing of avail, reject and grant
    for (int v = 0; v < NV; v++) begin
      logic [10:0] r;
      r = VEC[v];
      chk("R2 R3 R6 avail", usrAvail, r[4]);
      chk("R4 reject", usrReject, r[3]);
      chk("R5 grant", intGrant, r[2]);
      intReq   = r[10]; usrWrEn = r[9]; usrSop = r[8]; usrEop = r[7];
      intWrEn  = r[6];  intEop  = r[5];
      intSop   = r[6] & intSopNext;
      if (r[6]) intSopNext = r[5];
      usrDatLo = {16'hA000, 16'(v)}; usrDatHi = {16'hB000, 16'(v)}; usrEmpty = 3'(v);
      intDatLo = {16'hC000, 16'(v)}; intDatHi = {16'hD000, 16'(v)}; intEmpty = 3'(v + 3);
      if (r[1:0] == 2'd1) expQ[wrIdx++] = {usrDatLo, usrDatHi, usrSop, usrEop, usrEmpty};
      if (r[1:0] == 2'd2) expQ[wrIdx++] = {intDatLo, intDatHi, intSop, intEop, intEmpty};
      @(negedge clk);
      idleIn();
    end

    // R7: fill until free space drops below one maximum packet
    for (int k = 0; k < 3; k++) begin
      chk("R7 avail before fill", usrAvail, 1'b1);
      usrWrEn = 1; usrSop = 1; usrEop = 1;
      usrDatLo = 32'hE000_0000 + k; usrDatHi = 32'hF000_0000 + k; usrEmpty = 3'(k);
      expQ[wrIdx++] = {usrDatLo, usrDatHi, 1'b1, 1'b1, usrEmpty};
      @(negedge clk);
      idleIn();
    end
    chk("R7 avail low on space", usrAvail, 1'b0);
    usrWrEn = 1; usrSop = 1; usrEop = 1; usrDatLo = 32'h0BAD_0BAD;
    @(negedge clk);
    idleIn();
    chk("R7 R4 reject on space", usrReject, 1'b1);

    // R8 R9: drain and compare order and fields
    while (rdIdx < wrIdx) begin
      chk("R8 rdValid", rdValid, 1'b1);
      chk("R8 beat", {rdDatLo, rdDatHi, rdSop, rdEop, rdEmpty}, expQ[rdIdx]);
      rdIdx++;
      rdEn = 1;
      @(negedge clk);
      rdEn = 0;
    end
    chk("R9 R4 no extra beat", rdValid, 1'b0);
    chk("R6 avail after drain", usrAvail, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule